// File: doc/BRIEF.md
# Programmable Up-Counter Timer with Capture and Waveform Output

This block is a 32-bit up-counting timer peripheral that sits behind a simple memory-mapped register port. The port has a byte offset, a write strobe, write data and read data. Software programs a clock prescaler, a reload value and a compare value. It then starts the counter, which either reloads itself on overflow or stops there. The timer records overflow, compare and capture events in a status register. An interrupt line is the masked OR of those status bits.

A synchronized external input can snapshot the running count on a rising edge, a falling edge or either edge. A waveform pin either pulses for one clock or toggles on overflow, or on overflow and match. Register writes are posted: each write lands one clock after it is issued, and a pending register shows when a write is still in flight. Writing the trigger register copies the reload value into the counter. A soft reset clears the register file and then raises a completion flag after a fixed number of clocks.

Top module: `tmr_unit`

## Requirements
- R1: After the synchronous reset, the control, counter, status, capture and load registers read 0, `irq` and `wave_out` are 0, and the reset-done flag (bit 0 at offset 0x14, and port `reset_done`) is 1.
- R2: Registers read back what was written, limited to their width. Control at 0x24 keeps bits 14:0. Interrupt enable at 0x1C keeps bits 2:0. Load 0x2C, match 0x38 and counter 0x28 keep 32 bits.
- R3: A write takes effect at the second rising edge after the cycle in which `bus_we` is sampled. Offset 0x34 reads 1 between those two edges and 0 otherwise.
- R4: A write of any value to offset 0x30 copies the load register into the counter.
- R5: The counter runs while control bit 0 is 1. With control bit 5 at 0, it adds 1 on every clock. With control bit 5 at 1, it adds 1 once every 2^(P+1) clocks, where P is control bits 4:2.
- R6: When a tick arrives with the counter at 0xFFFFFFFF, the counter takes the load value if control bit 1 is 1. Otherwise it becomes 0 and control bit 0 clears.
- R7: Status at 0x18 sets bit 0 on match, bit 1 on overflow and bit 2 on capture. Writing 1 to a status bit clears it. `irq` is high when any status bit is set together with its enable bit at 0x1C.
- R8: With control bit 6 at 1, a tick that makes the counter equal to the match register sets status bit 0 at the same edge.
- R9: Control bits 9:8 pick the capture edge of `cap_in`: 01 rising, 10 falling, 11 either, 00 none. The count present when the edge is seen goes into offset 0x3C and sets status bit 2, three edges after the input changes.
- R10: Control bits 11:10 pick the output event: 00 none, 01 overflow, 10 or 11 overflow or match. With control bit 12 at 0, `wave_out` leaves the level given by control bit 7 for one clock at the event edge. With bit 12 at 1, it inverts on each event.
- R11: Writing a value with bit 1 set to offset 0x40 clears all registers and drops the reset-done flag. The flag returns to 1 after RST_CYCLES (default 4) further clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| wave_out | output | 1 | Pulse or toggle output |
| irq | output | 1 | Level interrupt |
| reset_done | output | 1 | Soft reset complete |

## Verification
Each result is due at a fixed number of clock edges after its stimulus. A posted write becomes visible two edges after the strobe, so every write helper returns at the falling edge just after the write lands, and the pending flag is sampled one edge earlier. After a start write lands, each count arrives one edge later, or 2^(P+1) edges later with the prescaler. Overflow, match, status, `irq` and `wave_out` change on the same edge as the count that caused them. A capture lands three edges after `cap_in` moves. All checks read at falling edges counted from those points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PRE_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_SYSST = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CNT   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_WPEND = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_MATCH = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_CAPT  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_SRST  = 8'h40;

    typedef struct packed {
        logic              gpo;
        logic              cmode;
        logic              toggle;
        logic [1:0]        out_sel;
        logic [1:0]        edge_sel;
        logic              def_lvl;
        logic              cmp_en;
        logic              pre_en;
        logic [2:0]        ptv;
        logic              autold;
        logic              run;
    } ctrl_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } post_t;

    function automatic logic [PRE_W-1:0] pre_mask(input logic [2:0] ptv);
        logic [PRE_W:0] m;
        m = (9'd2 << ptv) - 9'd1;
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       en,
    input  logic [2:0] ptv,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] mask;

    assign mask = pre_mask(ptv);
    assign tick = run && (!en || ((pcnt_q & mask) == mask));

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       cap_evt
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign cap_evt = (edge_sel[0] && s2_q && !s3_q) ||
                     (edge_sel[1] && !s2_q && s3_q);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ev_ovf,
    input  logic       ev_mat,
    input  logic [1:0] sel,
    input  logic       toggle,
    input  logic       def_lvl,
    output logic       wave
);
    logic fire;
    logic pulse_q, tog_q;

    always_comb begin
        unique case (sel)
            2'b00:   fire = 1'b0;
            2'b01:   fire = ev_ovf;
            default: fire = ev_ovf || ev_mat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= fire && !toggle;
            if (fire && toggle) tog_q <= !tog_q;
        end
    end

    assign wave = def_lvl ^ (toggle ? tog_q : pulse_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              wave_out,
    output logic              irq,
    output logic              reset_done
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;

    post_t             pw_q;
    ctrl_t             ctl_q;
    logic [2:0]        st_q, ien_q;
    logic [DATA_W-1:0] cnt_q, load_q, match_q, cap_q;
    logic [RC_W-1:0]   rc_q;

    logic busy, sr_start, wr_ok, tick, ev_ovf, ev_mat, ev_cap;
    logic wr_ctrl, wr_cnt, wr_trig;
    logic [DATA_W-1:0] cnt_step;

    assign busy     = (rc_q != '0);
    assign sr_start = pw_q.vld && !busy && (pw_q.addr == OFF_SRST) && pw_q.data[1];
    assign wr_ok    = pw_q.vld && !busy && !sr_start;
    assign wr_ctrl  = wr_ok && (pw_q.addr == OFF_CTRL);
    assign wr_cnt   = wr_ok && (pw_q.addr == OFF_CNT);
    assign wr_trig  = wr_ok && (pw_q.addr == OFF_TRIG);

    tmr_prescale u_pre (
        .clk(clk), .rst(rst), .run(ctl_q.run && !busy),
        .en(ctl_q.pre_en), .ptv(ctl_q.ptv), .tick(tick)
    );

    tmr_capture u_cap (
        .clk(clk), .rst(rst), .pin(cap_in),
        .edge_sel(ctl_q.edge_sel), .cap_evt(ev_cap)
    );

    tmr_wave u_wave (
        .clk(clk), .rst(rst), .clr(sr_start), .ev_ovf(ev_ovf), .ev_mat(ev_mat),
        .sel(ctl_q.out_sel), .toggle(ctl_q.toggle), .def_lvl(ctl_q.def_lvl),
        .wave(wave_out)
    );

    assign ev_ovf   = tick && (cnt_q == CNT_MAX);
    assign cnt_step = ev_ovf ? (ctl_q.autold ? load_q : '0) : cnt_q + 1'b1;
    assign ev_mat   = tick && ctl_q.cmp_en && (cnt_step == match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_q    <= '0;
            ctl_q   <= '0;
            st_q    <= '0;
            ien_q   <= '0;
            cnt_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
            cap_q   <= '0;
            rc_q    <= '0;
        end else begin
            pw_q <= '{vld: bus_we, addr: bus_addr, data: bus_wdata};
            if (sr_start) begin
                ctl_q   <= '0;
                st_q    <= '0;
                ien_q   <= '0;
                cnt_q   <= '0;
                load_q  <= '0;
                match_q <= '0;
                cap_q   <= '0;
                rc_q    <= RC_W'(RST_CYCLES);
            end else if (busy) begin
                rc_q <= rc_q - 1'b1;
            end else begin
                if (tick) cnt_q <= cnt_step;
                if (ev_ovf && !ctl_q.autold) ctl_q.run <= 1'b0;
                if (ev_cap) cap_q <= cnt_q;
                st_q <= (st_q & ~((wr_ok && pw_q.addr == OFF_STAT) ? pw_q.data[2:0] : 3'b000))
                        | {ev_cap, ev_ovf, ev_mat};
                if (wr_ctrl) ctl_q <= ctrl_t'(pw_q.data[14:0]);
                if (wr_cnt)  cnt_q <= pw_q.data;
                else if (wr_trig) cnt_q <= load_q;
                if (wr_ok && pw_q.addr == OFF_LOAD)  load_q  <= pw_q.data;
                if (wr_ok && pw_q.addr == OFF_MATCH) match_q <= pw_q.data;
                if (wr_ok && pw_q.addr == OFF_IEN)   ien_q   <= pw_q.data[2:0];
            end
        end
    end

    assign irq        = |(st_q & ien_q);
    assign reset_done = !busy;

    always_comb begin
        unique case (bus_addr)
            OFF_SYSST: bus_rdata = {31'b0, !busy};
            OFF_STAT:  bus_rdata = {29'b0, st_q};
            OFF_IEN:   bus_rdata = {29'b0, ien_q};
            OFF_CTRL:  bus_rdata = {17'b0, ctl_q};
            OFF_CNT:   bus_rdata = cnt_q;
            OFF_LOAD:  bus_rdata = load_q;
            OFF_WPEND: bus_rdata = {31'b0, pw_q.vld};
            OFF_MATCH: bus_rdata = match_q;
            OFF_CAPT:  bus_rdata = cap_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R3: a sampled write is pending on the following cycle
    a_r3_pend_follows_write: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> pw_q.vld);

    // R5: a plain tick adds exactly one
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q != CNT_MAX && !wr_cnt && !wr_trig && !sr_start)
        |=> cnt_q == $past(cnt_q) + 1'b1);

    // R6: one-shot overflow clears the run bit
    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (ev_ovf && !ctl_q.autold && !wr_ctrl && !sr_start) |=> !ctl_q.run);

    // R7: overflow is recorded in status
    a_r7_ovf_sets_status: assert property (@(posedge clk) disable iff (rst)
        (ev_ovf && !sr_start) |=> st_q[1]);

    // R11: soft reset drops the done flag next cycle
    a_r11_srst_busy: assert property (@(posedge clk) disable iff (rst)
        sr_start |=> !reset_done);

endmodule

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        cap_in;
    logic        wave_out, irq, reset_done;

    int n_run = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    tmr_unit dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .wave_out(wave_out), .irq(irq), .reset_done(reset_done)
    );

    // {addr, write data, expected readback}: R2
    localparam logic [71:0] VEC [6] = '{
        {8'h2C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h38, 32'h0000_1234, 32'h0000_1234},
        {8'h1C, 32'hFFFF_FFFF, 32'h0000_0007},
        {8'h28, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
        {8'h24, 32'hFFFF_FFFE, 32'h0000_7FFE},
        {8'h1C, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // returns at the falling edge right after the write has landed
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; cap_in = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(8'h24, v); chk("R1 ctrl", v, 0);
        rd(8'h28, v); chk("R1 cnt", v, 0);
        rd(8'h18, v); chk("R1 status", v, 0);
        rd(8'h14, v); chk("R1 sysstat", v, 1);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 wave", {31'b0, wave_out}, 0);
        chk("R1 reset_done", {31'b0, reset_done}, 1);

        // R2 table-driven readback
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R2 readback", v, VEC[i][31:0]);
        end
        wr(8'h24, 0);

        // R3 write pending
        @(negedge clk);
        bus_addr = 8'h2C; bus_we = 1'b1; bus_wdata = 32'h77;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h34, v); chk("R3 pending high", v, 1);
        rd(8'h2C, v); chk("R3 not yet landed", v, 32'hDEAD_BEEF);
        @(negedge clk);
        rd(8'h34, v); chk("R3 pending low", v, 0);
        rd(8'h2C, v); chk("R3 landed", v, 32'h77);

        // R4 trigger reload
        wr(8'h2C, 32'h100);
        wr(8'h30, 32'h0);
        rd(8'h28, v); chk("R4 trigger", v, 32'h100);

        // R5 plain counting
        wr(8'h28, 10);
        wr(8'h24, 32'h1);
        step(5);
        rd(8'h28, v); chk("R5 no prescale", v, 15);
        wr(8'h24, 0);

        // R5 prescaler P=1: one tick per 4 clocks
        wr(8'h28, 0);
        wr(8'h24, 32'h1 | 32'h20 | (32'h1 << 2));
        step(7);
        rd(8'h28, v); chk("R5 prescale 7 clk", v, 1);
        step(1);
        rd(8'h28, v); chk("R5 prescale 8 clk", v, 2);
        wr(8'h24, 0);

        // R6/R7/R10 overflow with reload, pulse on overflow
        wr(8'h18, 7);
        wr(8'h28, 32'hFFFF_FFFE);
        wr(8'h2C, 5);
        wr(8'h1C, 2);
        wr(8'h24, 32'h1 | 32'h2 | (32'h1 << 10));
        step(1);
        rd(8'h28, v); chk("R6 pre-overflow", v, 32'hFFFF_FFFF);
        chk("R10 pulse idle", {31'b0, wave_out}, 0);
        step(1);
        rd(8'h28, v); chk("R6 reload", v, 5);
        chk("R7 irq on overflow", {31'b0, irq}, 1);
        chk("R10 pulse high", {31'b0, wave_out}, 1);
        step(1);
        chk("R10 pulse one clock", {31'b0, wave_out}, 0);
        wr(8'h24, 0);
        wr(8'h18, 2);
        chk("R7 W1C clears irq", {31'b0, irq}, 0);

        // R6 one-shot stop
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h24, 32'h1);
        step(3);
        rd(8'h28, v); chk("R6 one-shot to zero", v, 0);
        rd(8'h24, v); chk("R6 run cleared", v, 0);
        rd(8'h18, v); chk("R7 overflow status", v, 2);
        wr(8'h18, 7);

        // R8/R10 compare match with toggle, default level 1
        wr(8'h28, 0);
        wr(8'h38, 3);
        wr(8'h24, 32'h80);
        chk("R10 default level", {31'b0, wave_out}, 1);
        wr(8'h24, 32'h1 | 32'h40 | 32'h80 | (32'h2 << 10) | (32'h1 << 12));
        step(2);
        rd(8'h18, v); chk("R8 no early match", v, 0);
        step(1);
        rd(8'h28, v); chk("R8 count at match", v, 3);
        rd(8'h18, v); chk("R8 match status", v, 1);
        chk("R10 toggled", {31'b0, wave_out}, 0);
        wr(8'h24, 0);
        wr(8'h18, 7);

        // R9 capture, rising only
        wr(8'h28, 32'h1234);
        wr(8'h24, 32'h1 << 8);
        cap_in = 1'b1;
        step(2);
        rd(8'h18, v); chk("R9 not yet", v, 0);
        step(1);
        rd(8'h3C, v); chk("R9 rising capture", v, 32'h1234);
        rd(8'h18, v); chk("R9 capture status", v, 4);
        chk("R7 masked irq", {31'b0, irq}, 0);
        wr(8'h1C, 4);
        chk("R7 enabled irq", {31'b0, irq}, 1);
        wr(8'h28, 32'h55);
        cap_in = 1'b0;
        step(4);
        rd(8'h3C, v); chk("R9 falling ignored", v, 32'h1234);
        wr(8'h24, 32'h3 << 8);
        cap_in = 1'b1;
        step(3);
        rd(8'h3C, v); chk("R9 either edge", v, 32'h55);

        // R11 soft reset
        wr(8'h40, 32'h06);
        rd(8'h14, v); chk("R11 busy", v, 0);
        rd(8'h24, v); chk("R11 ctrl cleared", v, 0);
        rd(8'h2C, v); chk("R11 load cleared", v, 0);
        step(3);
        chk("R11 still busy", {31'b0, reset_done}, 0);
        step(1);
        chk("R11 done", {31'b0, reset_done}, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule